// File: doc/BRIEF.md
# Audio Transmit/Receive FIFO Pair with Watermark Requests and Interrupts

This block buffers 16-bit audio words in two directions between a register interface and a serial audio port. The transmit FIFO is loaded by the register side and drained by the serial shifter. The receive FIFO is loaded by the shifter and drained by the register side. Each FIFO holds 32 words. It reports its fill level and four level flags in a packed status word. It also raises a DMA request by comparing its level against a 6-bit programmable watermark.

A 13-source interrupt block latches level conditions, data-path errors and word transfers. Each source has its own enable. A summary pending bit covers the enabled sources, and a global enable gates the interrupt line. Latched bits are cleared by a write-one-to-clear strobe. The serial shifter and the bus fabric are outside the block. Simple strobes and valid flags stand in for them.

Top module: `audio_fifo_pair`

## Requirements
- R1: Each FIFO returns words in the order written. A read word carries the data in bits 15:0 and a valid flag in bit 16. When the FIFO is empty or disabled, the word reads as all zero with the valid flag at 0.
- R2: Each FIFO holds up to 32 words. The status word carries the transmit count in bits 19:14 and the receive count in bits 9:4.
- R3: Each direction has four flags: empty (count is 0), almost-empty (count ≤ 4), full (count is 32) and almost-full (count ≥ 28). The transmit flags sit in status bits 13,12,11,10 in that order, and the receive flags in bits 3,2,1,0.
- R4: A write to a full enabled FIFO is dropped and leaves the count unchanged. It latches the overflow source: bit 6 for transmit, bit 0 for receive.
- R5: A shifter request on an empty enabled transmit FIFO latches transmit starve (bit 7). A register read of an empty enabled receive FIFO latches receive starve (bit 1). Neither access changes the count.
- R6: The transmit DMA request is high while the transmit DMA enable and the transmit FIFO enable are both set and the transmit count is at or below the transmit watermark.
- R7: The receive DMA request is high while the receive DMA enable and the receive FIFO enable are both set and the receive count is at or above the receive watermark.
- R8: A FIFO whose enable is low is flushed to count 0 at the next clock edge, and all accesses to it are ignored.
- R9: Interrupt sources latch until cleared. The transmit sources are empty, almost-empty, full and almost-full at bits 11,10,9,8. The receive sources in the same order are at bits 5,4,3,2. A level source latches only while its FIFO is enabled.
- R10: While the clear strobe is high, each 1 in the clear mask clears that latched bit. A source that sets in the same cycle keeps its bit set.
- R11: Interrupt status bit 13 is the OR of the latched sources masked by their enables. The interrupt line equals that bit ANDed with the global enable.
- R12: Source bit 12 latches on any serial-side transfer: a word popped by the shifter or a word accepted from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_fifo_en | input | 1 | Transmit FIFO enable (low flushes) |
| rx_fifo_en | input | 1 | Receive FIFO enable (low flushes) |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| tx_mark | input | 6 | Transmit watermark |
| rx_mark | input | 6 | Receive watermark |
| src_en | input | 13 | Per-source interrupt enables |
| irq_global_en | input | 1 | Global interrupt enable |
| clr_wr | input | 1 | Clear strobe |
| clr_mask | input | 13 | Write-one-to-clear mask |
| tx_wr_valid | input | 1 | Register-side write to the transmit FIFO |
| tx_wr_data | input | 16 | Word to write |
| rx_rd | input | 1 | Register-side read (pop) of the receive FIFO |
| rx_rd_word | output | 17 | Receive head word {valid, data} |
| sh_tx_req | input | 1 | Shifter request (pop) from the transmit FIFO |
| sh_tx_word | output | 17 | Transmit head word {valid, data} |
| sh_rx_valid | input | 1 | Shifter delivers a received word |
| sh_rx_data | input | 16 | Received word |
| fifo_stat | output | 20 | Counts and level flags |
| irq_stat | output | 14 | {pending, latched sources} |
| irq_out | output | 1 | Interrupt line |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
A count that is off by one shows in the very next cycle in the status count fields, the flags and the DMA requests. It also moves the point where overflow or starve latches, so the bench compares every output on every cycle against a queue model. A wrong read or write pointer shows as a wrong head word as soon as that entry reaches the head. A wrong set/clear priority in the interrupt latches appears one cycle after the clear strobe. Random traffic with random watermarks, clears and occasional flushes is mixed with directed fills past full and drains past empty.

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair #(
  parameter int DW = 16,
  parameter int DEPTH = 32,
  parameter int AE_MARGIN = 4,
  parameter int AF_MARGIN = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tx_fifo_en,
  input  logic                              rx_fifo_en,
  input  logic                              tx_dma_en,
  input  logic                              rx_dma_en,
  input  logic [$clog2(DEPTH+1)-1:0]        tx_mark,
  input  logic [$clog2(DEPTH+1)-1:0]        rx_mark,
  input  logic [12:0]                       src_en,
  input  logic                              irq_global_en,
  input  logic                              clr_wr,
  input  logic [12:0]                       clr_mask,
  input  logic                              tx_wr_valid,
  input  logic [DW-1:0]                     tx_wr_data,
  input  logic                              rx_rd,
  output logic [DW:0]                       rx_rd_word,
  input  logic                              sh_tx_req,
  output logic [DW:0]                       sh_tx_word,
  input  logic                              sh_rx_valid,
  input  logic [DW-1:0]                     sh_rx_data,
  output logic [2*($clog2(DEPTH+1)+4)-1:0]  fifo_stat,
  output logic [13:0]                       irq_stat,
  output logic                              irq_out,
  output logic                              tx_dma_req,
  output logic                              rx_dma_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] AE_C = CW'(AE_MARGIN);
  localparam logic [CW-1:0] AF_C = CW'(DEPTH - AF_MARGIN);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [12:0]   latched;

  wire tx_full  = tx_cnt == FULL_C;
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == FULL_C;
  wire rx_empty = rx_cnt == '0;
  wire tx_ae = tx_cnt <= AE_C;
  wire tx_af = tx_cnt >= AF_C;
  wire rx_ae = rx_cnt <= AE_C;
  wire rx_af = rx_cnt >= AF_C;

  wire tx_push   = tx_fifo_en && tx_wr_valid && !tx_full;
  wire tx_ovf    = tx_fifo_en && tx_wr_valid && tx_full;
  wire tx_pop    = tx_fifo_en && sh_tx_req && !tx_empty;
  wire tx_starve = tx_fifo_en && sh_tx_req && tx_empty;
  wire rx_push   = rx_fifo_en && sh_rx_valid && !rx_full;
  wire rx_ovf    = rx_fifo_en && sh_rx_valid && rx_full;
  wire rx_pop    = rx_fifo_en && rx_rd && !rx_empty;
  wire rx_starve = rx_fifo_en && rx_rd && rx_empty;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wr_data;
    if (rx_push) rx_mem[rx_wp] <= sh_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (!tx_fifo_en) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (!rx_fifo_en) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  wire tx_ok = tx_fifo_en && !tx_empty;
  wire rx_ok = rx_fifo_en && !rx_empty;
  assign sh_tx_word = tx_ok ? {1'b1, tx_mem[tx_rp]} : '0;
  assign rx_rd_word = rx_ok ? {1'b1, rx_mem[rx_rp]} : '0;

  assign fifo_stat = {tx_cnt, tx_empty, tx_ae, tx_full, tx_af,
                      rx_cnt, rx_empty, rx_ae, rx_full, rx_af};

  assign tx_dma_req = tx_dma_en && tx_fifo_en && (tx_cnt <= tx_mark);
  assign rx_dma_req = rx_dma_en && rx_fifo_en && (rx_cnt >= rx_mark);

  wire [12:0] set_v = {tx_pop || rx_push,
                       {4{tx_fifo_en}} & {tx_empty, tx_ae, tx_full, tx_af},
                       tx_starve, tx_ovf,
                       {4{rx_fifo_en}} & {rx_empty, rx_ae, rx_full, rx_af},
                       rx_starve, rx_ovf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latched <= '0;
    else        latched <= (latched & ~(clr_wr ? clr_mask : 13'd0)) | set_v;
  end

  wire pending = |(latched & src_en);
  assign irq_stat = {pending, latched};
  assign irq_out  = pending && irq_global_en;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL_C && rx_cnt <= FULL_C);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fifo_en && tx_wr_valid && tx_cnt == FULL_C && !sh_tx_req) |=> (tx_cnt == FULL_C && irq_stat[6]));
  p_rx_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_en && sh_rx_valid && rx_cnt == FULL_C) |=> irq_stat[0]);
  p_starve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fifo_en && sh_tx_req && tx_cnt == '0) |=> (irq_stat[7] && tx_cnt <= CW'(1)));
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_fifo_en |=> (tx_cnt == '0 && sh_tx_word[DW] == 1'b0));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_mask[12] && !sh_tx_req && !sh_rx_valid) |=> !irq_stat[12]);
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irq_global_en && irq_stat[13]));
endmodule

// File: tb/audio_fifo_pair_test.sv
module audio_fifo_pair_test;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic tx_fifo_en = 0, rx_fifo_en = 0, tx_dma_en = 0, rx_dma_en = 0;
  logic [5:0] tx_mark = 0, rx_mark = 0;
  logic [12:0] src_en = 0, clr_mask = 0;
  logic irq_global_en = 0, clr_wr = 0;
  logic tx_wr_valid = 0, rx_rd = 0, sh_tx_req = 0, sh_rx_valid = 0;
  logic [15:0] tx_wr_data = 0, sh_rx_data = 0;
  logic [16:0] rx_rd_word, sh_tx_word;
  logic [19:0] fifo_stat;
  logic [13:0] irq_stat;
  logic irq_out, tx_dma_req, rx_dma_req;

  audio_fifo_pair uut (.*);

  int checks = 0, fails = 0;
  logic [15:0] tq[$], rq[$];
  logic [12:0] m_lat = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] flags(int c);
    return {c == 0, c <= 4, c == 32, c >= 28};
  endfunction

  function automatic logic [16:0] head(logic en, logic [15:0] q[$]);
    return (en && q.size() > 0) ? {1'b1, q[0]} : 17'd0;
  endfunction

  task automatic model_step();
    int tc = tq.size(), rc = rq.size();
    logic tpush = tx_fifo_en && tx_wr_valid && tc < 32;
    logic tovf  = tx_fifo_en && tx_wr_valid && tc == 32;
    logic tpop  = tx_fifo_en && sh_tx_req && tc > 0;
    logic tstv  = tx_fifo_en && sh_tx_req && tc == 0;
    logic rpush = rx_fifo_en && sh_rx_valid && rc < 32;
    logic rovf  = rx_fifo_en && sh_rx_valid && rc == 32;
    logic rpop  = rx_fifo_en && rx_rd && rc > 0;
    logic rstv  = rx_fifo_en && rx_rd && rc == 0;
    logic [12:0] s;
    s = {tpop || rpush, tx_fifo_en ? flags(tc) : 4'd0, tstv, tovf,
         rx_fifo_en ? flags(rc) : 4'd0, rstv, rovf};
    m_lat = (m_lat & ~(clr_wr ? clr_mask : 13'd0)) | s;
    if (!tx_fifo_en) tq.delete();
    else begin
      if (tpop) void'(tq.pop_front());
      if (tpush) tq.push_back(tx_wr_data);
    end
    if (!rx_fifo_en) rq.delete();
    else begin
      if (rpop) void'(rq.pop_front());
      if (rpush) rq.push_back(sh_rx_data);
    end
  endtask

  task automatic check_all();
    int tc = tq.size(), rc = rq.size();
    logic pend = |(m_lat & src_en);
    chk("R1 tx head", sh_tx_word, head(tx_fifo_en, tq));
    chk("R1 rx head", rx_rd_word, head(rx_fifo_en, rq));
    chk("R2 tx count", fifo_stat[19:14], tc);
    chk("R2 rx count", fifo_stat[9:4], rc);
    chk("R3 tx flags", fifo_stat[13:10], flags(tc));
    chk("R3 rx flags", fifo_stat[3:0], flags(rc));
    chk("R4 overflow bits", {irq_stat[6], irq_stat[0]}, {m_lat[6], m_lat[0]});
    chk("R5 starve bits", {irq_stat[7], irq_stat[1]}, {m_lat[7], m_lat[1]});
    chk("R6 tx dma", tx_dma_req, tx_dma_en && tx_fifo_en && tc <= tx_mark);
    chk("R7 rx dma", rx_dma_req, rx_dma_en && rx_fifo_en && rc >= rx_mark);
    chk("R9 level bits", {irq_stat[11:8], irq_stat[5:2]}, {m_lat[11:8], m_lat[5:2]});
    chk("R12 transfer bit", irq_stat[12], m_lat[12]);
    chk("R11 pending", irq_stat[13], pend);
    chk("R11 irq line", irq_out, pend && irq_global_en);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle_in();
    tx_wr_valid = 0; rx_rd = 0; sh_tx_req = 0; sh_rx_valid = 0; clr_wr = 0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R2 reset stat", fifo_stat, {6'd0, 4'b1100, 6'd0, 4'b1100});
    chk("R9 reset irq", irq_stat, 14'd0);
    rst_n = 1;
    @(negedge clk);
    tx_fifo_en = 1; rx_fifo_en = 1; tx_dma_en = 1; rx_dma_en = 1;
    tx_mark = 4; rx_mark = 32; src_en = 13'h1fff; irq_global_en = 1;
    // R5: starve both sides on empty
    sh_tx_req = 1; rx_rd = 1; cyc(); idle_in();
    chk("R5 tx starve latched", irq_stat[7], 1'b1);
    chk("R5 rx starve latched", irq_stat[1], 1'b1);
    // R4: fill transmit past full, receive past full
    for (int i = 0; i < 34; i++) begin
      tx_wr_valid = 1; tx_wr_data = 16'(16'h1000 + i);
      sh_rx_valid = 1; sh_rx_data = 16'(16'h2000 + i);
      cyc();
    end
    idle_in();
    chk("R4 tx full count", fifo_stat[19:14], 6'd32);
    chk("R4 tx overflow", irq_stat[6], 1'b1);
    chk("R7 rx dma at 32", rx_dma_req, 1'b1);
    chk("R1 first tx word", sh_tx_word, {1'b1, 16'h1000});
    // R10: clear everything while full; level bits stay, events go
    clr_wr = 1; clr_mask = 13'h1fff; cyc(); idle_in();
    chk("R10 overflow cleared", irq_stat[6], 1'b0);
    chk("R10 full kept (set wins)", irq_stat[9], 1'b1);
    // drain both
    for (int i = 0; i < 33; i++) begin sh_tx_req = 1; rx_rd = 1; cyc(); end
    idle_in();
    chk("R1 drained tx", sh_tx_word, 17'd0);
    chk("R6 tx dma when empty", tx_dma_req, 1'b1);
    // R8: flush by disable
    for (int i = 0; i < 5; i++) begin tx_wr_valid = 1; tx_wr_data = 16'(i); cyc(); end
    idle_in();
    tx_fifo_en = 0; tx_wr_valid = 1; cyc(); idle_in();
    chk("R8 flushed count", fifo_stat[19:14], 6'd0);
    tx_fifo_en = 1; cyc();
    chk("R8 write while disabled ignored", sh_tx_word, 17'd0);
    // random traffic
    for (int n = 0; n < 6000; n++) begin
      tx_wr_valid = ($urandom % 100) < 50; tx_wr_data = 16'($urandom);
      sh_rx_valid = ($urandom % 100) < 50; sh_rx_data = 16'($urandom);
      sh_tx_req = ($urandom % 100) < 45;  rx_rd = ($urandom % 100) < 45;
      clr_wr = ($urandom % 8) == 0; clr_mask = 13'($urandom);
      if ($urandom % 64 == 0) begin
        tx_mark = 6'($urandom % 40); rx_mark = 6'($urandom % 40);
        src_en = 13'($urandom); irq_global_en = 1'($urandom);
        tx_dma_en = 1'($urandom); rx_dma_en = 1'($urandom);
      end
      tx_fifo_en = ($urandom % 200) != 0;
      rx_fifo_en = ($urandom % 200) != 0;
      if (n % 1500 < 300) sh_tx_req = 0;
      if (n % 1500 >= 700 && n % 1500 < 1000) rx_rd = 0;
      cyc();
    end
    idle_in();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule